// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bit-level half of an I2C master. A host hands it one command at a time over a valid/ready handshake. The four commands are: open a transfer with a START condition, close it with a STOP condition, shift a byte out, or shift a byte in and answer it with an acknowledge value chosen per byte. The engine generates the SCL and SDA timing itself. Both lines are open-drain: an output-enable of 1 pulls the line low, and 0 lets the pull-up hold it high. SDA is read back through a two-flop synchronizer.

Every bus bit takes three equal phases. Each phase lasts `divider + 1` clock cycles. In the first phase SDA is set while SCL is held low. In the second phase SCL is released high. In the third phase SCL is pulled low again. The divider is captured when a command is accepted. On the cycle after the last phase ends, a one-cycle `done` pulse is raised. It carries the received byte and the acknowledge bit sampled on the ninth clock. Addressing, arbitration and clock stretching belong to the layers around this block.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0, `cmd_ready` is 1 and `done` is 0. Both lines stay released whenever no transfer is open.
- R2: Command code 0 (START) lasts 4 phases. Phase 1 releases SDA and leaves SCL unchanged. Phase 2 releases SCL. Phase 3 pulls SDA low while SCL is high. Phase 4 pulls SCL low. It is accepted at any time, so it can also be a repeated start, and it opens a transfer.
- R3: During byte commands, SDA changes only while SCL is low. Neither a START nor a STOP pattern appears on the bus.
- R4: Command code 2 (write) places `cmd_data` on SDA most significant bit first, with one SCL pulse per bit. It uses 9 bits of 3 phases each, 27 phases in total.
- R5: On the ninth clock of a write, the engine releases SDA and samples it at the end of the SCL-high phase. `ack_seen` is 1 when the line was low.
- R6: Command code 3 (read) releases SDA for 8 bits. It samples SDA at the end of each SCL-high phase and shifts the value into bit 0 of a register, so the first bit received ends up in bit 7. `rd_data` holds the byte when `done` is raised.
- R7: On the ninth clock of a read, the engine pulls SDA low when `cmd_ack` was 1 and releases it when `cmd_ack` was 0. `ack_seen` reports the line level sampled on that clock, inverted.
- R8: Command code 1 (STOP) lasts 3 phases. Phase 1 pulls SDA low with SCL low. Phase 2 releases SCL. Phase 3 releases SDA while SCL is high. It closes the transfer and leaves both lines released.
- R9: While no transfer is open, a command other than START is accepted and dropped. It causes no line activity and no `done` pulse, and `cmd_ready` stays 1.
- R10: A command is accepted on a clock where `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` is then 0 until it completes. `done` is a one-cycle pulse raised exactly `phases * (divider + 1)` cycles after the accepting edge.
- R11: With `divider` of 1 or more, a data bit driven by a slave in response to an SCL falling edge is captured correctly through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write byte, 3 read byte |
| cmd_data | input | 8 | Byte to transmit (write) |
| cmd_ack | input | 1 | Read: 1 sends ACK, 0 sends NACK |
| divider | input | DIV_W | Phase length minus one, in clock cycles |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte received |
| ack_seen | output | 1 | Inverted SDA level sampled on the ninth clock |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
A command accepted on edge E0 raises `done` after edge E0 + N·(divider+1), where N is 4 for START, 3 for STOP and 27 for a byte. The bench samples on falling edges and counts cycles from the accepting edge, so any slip of even one cycle shows up. The received byte and `ack_seen` are read in the `done` cycle itself. Bus-level results (bit order, the ninth bit, START and STOP patterns) are reconstructed by a monitor at each SCL rise and compared once the command has finished. A slave model answers half a cycle after each SCL fall, which exercises the synchronizer margin.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    localparam int BYTE_BITS = 8;

    // Line enables for the phase being entered: {scl_oe, sda_oe}
    function automatic logic [1:0] line_drive(
        input op_e        op,
        input logic [3:0] bitn,
        input logic [1:0] sub,
        input logic       tx_bit,
        input logic       ack_drv,
        input logic       scl_keep
    );
        logic scl;
        logic sda;
        scl = 1'b0;
        sda = 1'b0;
        case (op)
            OP_START: begin
                case (sub)
                    2'd0:    begin scl = scl_keep; sda = 1'b0; end
                    2'd1:    begin scl = 1'b0;     sda = 1'b0; end
                    2'd2:    begin scl = 1'b0;     sda = 1'b1; end
                    default: begin scl = 1'b1;     sda = 1'b1; end
                endcase
            end
            OP_STOP: begin
                case (sub)
                    2'd0:    begin scl = 1'b1; sda = 1'b1; end
                    2'd1:    begin scl = 1'b0; sda = 1'b1; end
                    default: begin scl = 1'b0; sda = 1'b0; end
                endcase
            end
            default: begin
                scl = (sub != 2'd1);
                if (bitn < 4'(BYTE_BITS)) begin
                    sda = (op == OP_WRITE) ? ~tx_bit : 1'b0;
                end else begin
                    sda = (op == OP_WRITE) ? 1'b0 : ack_drv;
                end
            end
        endcase
        return {scl, sda};
    endfunction

endpackage

// File: rtl/i2c_bm_sync.sv
module i2c_bm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_bm_timer.sv
module i2c_bm_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        cnt_d = cnt_q;
        if (load) begin
            lim_d = div;
            cnt_d = div;
        end else if (cnt_q == '0) begin
            cnt_d = lim_q;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lim_q <= lim_d;
        end
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_data,
    input  logic             cmd_ack,
    input  logic [DIV_W-1:0] divider,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             ack_seen,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam logic [3:0] LAST_BIT   = 4'(BYTE_BITS);
    localparam logic [1:0] LAST_SUB_B = 2'd2;
    localparam logic [1:0] LAST_SUB_S = 2'd3;
    localparam logic [1:0] LAST_SUB_P = 2'd2;

    typedef struct packed {
        logic       busy;
        logic       started;
        op_e        op;
        logic [3:0] bitn;
        logic [1:0] sub;
        logic [7:0] sh;
        logic       ack_drv;
        logic       ack;
        logic [7:0] rd;
        logic       done;
        logic       scl_oe;
        logic       sda_oe;
    } state_t;

    state_t s_d, s_q;
    logic   tmr_load, tmr_expire;
    logic   sda_s;
    logic   is_byte, is_last, enter;
    op_e    op_in;

    i2c_bm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
    );

    i2c_bm_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .div(divider), .expire(tmr_expire)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        enter    = 1'b0;
        op_in    = op_e'(cmd_op);
        is_byte  = (s_q.op == OP_WRITE) || (s_q.op == OP_READ);
        case (s_q.op)
            OP_START: is_last = (s_q.sub == LAST_SUB_S);
            OP_STOP:  is_last = (s_q.sub == LAST_SUB_P);
            default:  is_last = (s_q.bitn == LAST_BIT) && (s_q.sub == LAST_SUB_B);
        endcase

        if (!s_q.busy) begin
            if (cmd_valid && (op_in == OP_START || s_q.started)) begin
                s_d.busy    = 1'b1;
                s_d.op      = op_in;
                s_d.bitn    = '0;
                s_d.sub     = '0;
                s_d.sh      = (op_in == OP_WRITE) ? cmd_data : 8'h00;
                s_d.ack_drv = cmd_ack;
                if (op_in == OP_START) s_d.started = 1'b1;
                tmr_load    = 1'b1;
                enter       = 1'b1;
            end
        end else if (tmr_expire) begin
            if (is_byte && s_q.sub == 2'd1) begin
                if (s_q.bitn < LAST_BIT) begin
                    if (s_q.op == OP_READ) s_d.sh = {s_q.sh[6:0], sda_s};
                end else begin
                    s_d.ack = ~sda_s;
                end
            end
            if (s_q.op == OP_WRITE && s_q.sub == 2'd2 && s_q.bitn < LAST_BIT) begin
                s_d.sh = {s_q.sh[6:0], 1'b0};
            end
            if (is_last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                if (s_q.op == OP_STOP) s_d.started = 1'b0;
                if (s_q.op == OP_READ) s_d.rd = s_d.sh;
            end else begin
                enter = 1'b1;
                if (is_byte && s_q.sub == LAST_SUB_B) begin
                    s_d.sub  = '0;
                    s_d.bitn = s_q.bitn + 1'b1;
                end else begin
                    s_d.sub = s_q.sub + 1'b1;
                end
            end
        end

        if (enter) begin
            {s_d.scl_oe, s_d.sda_oe} = line_drive(s_d.op, s_d.bitn, s_d.sub,
                                                  s_d.sh[7], s_d.ack_drv, s_q.scl_oe);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_ready = ~s_q.busy;
    assign done      = s_q.done;
    assign rd_data   = s_q.rd;
    assign ack_seen  = s_q.ack;
    assign scl_oe    = s_q.scl_oe;
    assign sda_oe    = s_q.sda_oe;

    logic       chk_busy, chk_started;
    logic [1:0] chk_op;
    assign chk_busy    = s_q.busy;
    assign chk_started = s_q.started;
    assign chk_op      = s_q.op;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       done,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       busy,
    input logic       started,
    input logic [1:0] op
);
    assert_lines_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!scl_oe && !sda_oe));

    assert_start_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> (busy && op == 2'd0));

    assert_sda_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op[1] && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

    assert_stop_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> (op == 2'd1));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 2'd0 || started)) |=> !cmd_ready);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(chk_busy), .started(chk_started), .op(chk_op)
);

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic        cmd_ack = 1'b0;
    logic [15:0] divider = 16'd1;
    logic        done, ack_seen, scl_oe, sda_oe;
    logic [7:0]  rd_data;
    logic        sda_in;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // bus lines and slave model
    logic       slave_pull;
    logic       scl_line, sda_line;
    int         sl_bit = 0, sl_base = 0, sl_mode = 0;
    logic [7:0] sl_byte = 8'h00;
    logic       sl_ack = 1'b0;
    logic       prev_scl_oe = 1'b0;
    int         rel;

    always_comb begin
        rel = sl_bit - sl_base;
        slave_pull = 1'b0;
        if (sl_mode == 1) slave_pull = (rel == 8) && sl_ack;
        else if (sl_mode == 2 && rel >= 0 && rel < 8) slave_pull = ~sl_byte[7 - rel];
    end
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_pull);
    assign sda_in   = sda_line;

    // bus monitor
    logic [8:0] cap = '0;
    int rises = 0, starts = 0, stops = 0;
    logic pscl = 1'b1, psda = 1'b1;

    always @(negedge clk) begin
        if (scl_oe && !prev_scl_oe) sl_bit <= sl_bit + 1;
        prev_scl_oe <= scl_oe;
        if (scl_line && !pscl) begin
            cap   <= {cap[7:0], sda_line};
            rises <= rises + 1;
        end
        if (scl_line && pscl && psda && !sda_line) starts <= starts + 1;
        if (scl_line && pscl && !psda && sda_line) stops <= stops + 1;
        pscl <= scl_line;
        psda <= sda_line;
    end

    i2c_byte_master u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_ack(cmd_ack), .divider(divider),
        .done(done), .rd_data(rd_data), .ack_seen(ack_seen),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int phases(input logic [1:0] op);
        return (op == 2'd0) ? 4 : (op == 2'd1) ? 3 : 27;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] data, input logic ack,
                           input logic [15:0] div, input int smode, input logic [7:0] sbyte,
                           input logic sack, output int cyc);
        @(negedge clk);
        sl_mode = smode; sl_byte = sbyte; sl_ack = sack; sl_base = sl_bit;
        cmd_valid = 1'b1; cmd_op = op; cmd_data = data; cmd_ack = ack; divider = div;
        chk(cmd_ready, "R10 ready before accept", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        chk(!cmd_ready, "R10 busy after accept", cmd_ready, 0);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == phases(op) * (int'(div) + 1), "R10 done latency", cyc, phases(op) * (int'(div) + 1));
        sl_mode = 0;
    endtask

    task automatic run_ignored(input logic [1:0] op);
        int r0;
        bit seen;
        r0 = rises;
        seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = 8'h5A; divider = 16'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 40; i++) begin
            seen |= done;
            chk(!scl_oe && !sda_oe && cmd_ready, "R9 lines released and ready", {scl_oe, sda_oe, cmd_ready}, 1);
            @(negedge clk);
        end
        chk(!seen, "R9 no done for dropped command", seen, 0);
        chk(rises == r0, "R9 no SCL activity", rises - r0, 0);
    endtask

    task automatic do_write(input logic [7:0] b, input logic sack, input logic [15:0] div);
        int cyc, s0, p0;
        s0 = starts; p0 = stops;
        run_cmd(2'd2, b, 1'b0, div, 1, 8'h00, sack, cyc);
        chk(ack_seen == sack, "R5 write ack_seen", ack_seen, sack);
        @(negedge clk);
        chk(cap[8:1] == b, "R4 byte on bus MSB first", cap[8:1], b);
        chk(cap[0] == ~sack, "R5 ninth bit level", cap[0], ~sack);
        chk(starts == s0 && stops == p0, "R3 no START/STOP inside byte", starts - s0 + stops - p0, 0);
    endtask

    task automatic do_read(input logic [7:0] b, input logic ack, input logic [15:0] div);
        int cyc, s0, p0;
        s0 = starts; p0 = stops;
        run_cmd(2'd3, 8'h00, ack, div, 2, b, 1'b0, cyc);
        chk(rd_data == b, "R6 read byte (R11 sync margin)", rd_data, b);
        chk(ack_seen == ack, "R7 read ack_seen", ack_seen, ack);
        @(negedge clk);
        chk(cap[0] == ~ack, "R7 master ninth bit on bus", cap[0], ~ack);
        chk(starts == s0 && stops == p0, "R3 no START/STOP inside byte", starts - s0 + stops - p0, 0);
    endtask

    task automatic do_start(input logic [15:0] div);
        int cyc, s0;
        s0 = starts;
        run_cmd(2'd0, 8'h00, 1'b0, div, 0, 8'h00, 1'b0, cyc);
        chk(starts == s0 + 1, "R2 START seen on bus", starts - s0, 1);
        chk(scl_oe && sda_oe, "R2 SCL and SDA low after START", {scl_oe, sda_oe}, 3);
    endtask

    task automatic do_stop(input logic [15:0] div);
        int cyc, p0;
        p0 = stops;
        run_cmd(2'd1, 8'h00, 1'b0, div, 0, 8'h00, 1'b0, cyc);
        chk(stops == p0 + 1, "R8 STOP seen on bus", stops - p0, 1);
        chk(!scl_oe && !sda_oe, "R8 lines released after STOP", {scl_oe, sda_oe}, 0);
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1 lines released at reset", {scl_oe, sda_oe}, 0);
        chk(cmd_ready && !done, "R1 ready, no done at reset", {cmd_ready, done}, 2);

        // R9 commands before START are dropped
        run_ignored(2'd2);
        run_ignored(2'd1);
        run_ignored(2'd3);

        // directed: start, corner bytes, stop
        do_start(16'd3);
        do_write(8'h80, 1'b1, 16'd1);
        do_write(8'h01, 1'b0, 16'd4);
        do_read(8'hFF, 1'b1, 16'd1);
        do_read(8'h00, 1'b0, 16'd2);
        do_stop(16'd2);
        run_ignored(2'd2);

        // random mix
        do_start(16'd0);
        for (int i = 0; i < 30; i++) begin
            int unsigned k;
            logic [15:0] dv;
            logic [7:0] b;
            k  = $urandom_range(0, 9);
            dv = 16'($urandom_range(1, 5));
            b  = 8'($urandom);
            if (k == 0) do_start(dv);                      // R2 repeated start
            else if (k < 5) do_write(b, 1'($urandom), dv);
            else do_read(b, 1'($urandom), dv);
        end
        do_read(8'hA5, 1'b0, 16'd3);                       // R7 last byte NACK
        do_stop(16'd1);
        chk(!scl_oe && !sda_oe && cmd_ready, "R1 released after transfer", {scl_oe, sda_oe, cmd_ready}, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule